// File: doc/BRIEF.md
# SPI serial clock generator

This block derives the serial bit clock of a SPI master from the system clock. It is used beneath a transfer sequencer, which owns the shift registers and the chip-select timing. While the sequencer holds the chip-select request high, the generator counts system cycles and toggles an internal clock. Each toggle is reported by a one-cycle strobe. The strobe tells the sequencer either to present the next bit (shift) or to capture the incoming bit (sample), following the clock polarity and phase settings.

Two divisors are held on separate inputs: one paces the write bits of a transfer and the other paces the read bits. The sequencer signals through a read-phase input which kind of bit comes next. The generator picks up that choice only at the trailing edge of each bit, so a bit is never stretched or cut when the phase changes. A stop request, also taken at a trailing edge, parks the clock at its idle level so chip-select can be released cleanly. The pin clock is gated by the chip-select request and given its idle level by the polarity setting. An offline input releases the pin through a separate output enable.

Top module: `spi_sck_gen`

## Requirements
- R1: Out of reset both strobes are low, `sck_o` equals `cpol_i`, and `sck_oe_o` is the inverse of `offline_i`.
- R2: Each bit lasts exactly d+2 system cycles, where d is the divisor in force for that bit. A divisor of 0 gives a bit clock of half the system clock.
- R3: A bit is split into two half-periods of floor((d+2)/2) and ceil((d+2)/2) cycles. The longer half, when the ratio is odd, always ends at the sample edge.
- R4: The leading edge of a bit (a rising internal clock) is a sample edge when `cpha_i`=0 and a shift edge when `cpha_i`=1; the trailing edge is the other kind. The pin shows the internal clock XOR `cpol_i`: after a leading edge it is !`cpol_i`, and after a trailing edge it is `cpol_i`.
- R5: A bit uses `div_rd_i` when `rd_phase_i` was 1 at the start of the run or at the previous bit's trailing edge, and `div_wr_i` otherwise.
- R6: While `run_i` is low, no strobe fires and `sck_o` stays at `cpol_i`. In the cycle `run_i` rises the pin is at idle level, and the first edge comes at least one cycle later, so no clock edge coincides with a chip-select edge.
- R7: A strobe is one cycle wide, `shift_o` and `sample_o` are never high together, and each strobe coincides with a change of `sck_o`.
- R8: When `stop_i` is high at a trailing edge, no further edges occur and `sck_o` rests at `cpol_i` until `run_i` falls.
- R9: While `offline_i` is 1, `sck_oe_o` is 0; when it is 0, `sck_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Chip-select active request from the sequencer |
| rd_phase_i | input | 1 | Next bit is a read bit (taken at run start and at trailing edges) |
| stop_i | input | 1 | Halt the clock at the next trailing edge |
| div_wr_i | input | DIV_W | Divisor for write bits |
| div_rd_i | input | DIV_W | Divisor for read bits |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on the leading edge, 1 shifts on it |
| offline_i | input | 1 | Release the clock pin |
| sck_o | output | 1 | Pin clock value |
| sck_oe_o | output | 1 | Pin clock output enable |
| shift_o | output | 1 | One-cycle strobe at each shift edge |
| sample_o | output | 1 | One-cycle strobe at each sample edge |

## Verification
The bench builds the block with its default divisor width of 8. At that width, divisors 0 to 7 give every small ratio from 2 to 9 system cycles per bit within a short run. This covers even and odd splits, the shortest half-period of one cycle, and a change of divisor between write and read bits. All four polarity and phase combinations are driven. Vectors with no write bits and with no read bits reach the phase-selection corners.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
   typedef enum logic [1:0] {
      SCK_IDLE = 2'd0,
      SCK_RUN  = 2'd1,
      SCK_HALT = 2'd2
   } sck_state_e;
endpackage

// File: rtl/spi_sck_halves.sv
// Converts a divisor into the reload values of the two half-periods.
// The half that ends on a sample edge receives the odd cycle.
module spi_sck_halves #(
   parameter int DIV_W = 8
) (
   input  logic [DIV_W-1:0] div_i,
   output logic [DIV_W-1:0] pre_sample_o,
   output logic [DIV_W-1:0] pre_shift_o
);
   localparam int RW = DIV_W + 1;

   logic [RW-1:0] ratio;
   logic [RW-1:0] long_half;
   logic [RW-1:0] short_half;

   always_comb begin
      ratio      = {1'b0, div_i} + RW'(2);
      long_half  = (ratio + RW'(1)) >> 1;
      short_half = ratio >> 1;
      pre_sample_o = DIV_W'(long_half - RW'(1));
      pre_shift_o  = DIV_W'(short_half - RW'(1));
   end
endmodule

// File: rtl/spi_sck_timer.sv
// Down-counter for one half-period; expires when it holds zero.
module spi_sck_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             en_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q <= '0;
      else if (load_i)                  cnt_q <= load_val_i;
      else if (en_i && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expire_o = en_i && (cnt_q == '0);

   p_cnt_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
   import spi_sck_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             rd_phase_i,
   input  logic             stop_i,
   input  logic [DIV_W-1:0] div_wr_i,
   input  logic [DIV_W-1:0] div_rd_i,
   input  logic             cpol_i,
   input  logic             cpha_i,
   input  logic             offline_i,
   output logic             sck_o,
   output logic             sck_oe_o,
   output logic             shift_o,
   output logic             sample_o
);
   localparam int NDIV  = 2;
   localparam int CNT_W = DIV_W;

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
      $error("spi_sck_gen: DIV_W must lie in 2..16");
   end

   sck_state_e       state_q;
   logic             iclk_q;
   logic             sel_rd_q;
   logic             shift_q;
   logic             sample_q;

   logic [DIV_W-1:0] div_arr    [NDIV];
   logic [DIV_W-1:0] pre_sample [NDIV];
   logic [DIV_W-1:0] pre_shift  [NDIV];

   assign div_arr[0] = div_wr_i;
   assign div_arr[1] = div_rd_i;

   for (genvar i = 0; i < NDIV; i++) begin : g_div
      spi_sck_halves #(.DIV_W(DIV_W)) u_halves (
         .div_i        (div_arr[i]),
         .pre_sample_o (pre_sample[i]),
         .pre_shift_o  (pre_shift[i])
      );
   end

   logic             start;
   logic             expire;
   logic             edge_now;
   logic             lead_edge;
   logic             trail_edge;
   logic             sel_next;
   logic             next_is_sample;
   logic             edge_is_sample;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      start          = (state_q == SCK_IDLE) && run_i;
      edge_now       = (state_q == SCK_RUN) && expire;
      lead_edge      = edge_now && !iclk_q;
      trail_edge     = edge_now && iclk_q;
      sel_next       = (start || trail_edge) ? rd_phase_i : sel_rd_q;
      next_is_sample = (start || trail_edge) ? !cpha_i : cpha_i;
      edge_is_sample = lead_edge ? !cpha_i : cpha_i;
      load_val       = next_is_sample ? pre_sample[sel_next] : pre_shift[sel_next];
   end

   spi_sck_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (start || edge_now),
      .load_val_i (load_val),
      .en_i       (state_q == SCK_RUN),
      .expire_o   (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= SCK_IDLE;
         iclk_q   <= 1'b0;
         sel_rd_q <= 1'b0;
         shift_q  <= 1'b0;
         sample_q <= 1'b0;
      end else begin
         shift_q  <= 1'b0;
         sample_q <= 1'b0;
         if (!run_i) begin
            state_q <= SCK_IDLE;
            iclk_q  <= 1'b0;
         end else begin
            case (state_q)
               SCK_IDLE: begin
                  state_q  <= SCK_RUN;
                  sel_rd_q <= rd_phase_i;
               end
               SCK_RUN: begin
                  if (edge_now) begin
                     iclk_q   <= !iclk_q;
                     sample_q <= edge_is_sample;
                     shift_q  <= !edge_is_sample;
                  end
                  if (trail_edge) begin
                     sel_rd_q <= rd_phase_i;
                     if (stop_i) state_q <= SCK_HALT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sck_o    = (iclk_q & run_i) ^ cpol_i;
   assign sck_oe_o = !offline_i;
   assign shift_o  = shift_q;
   assign sample_o = sample_q;

   p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(shift_o && sample_o));

   p_strobe_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_o || sample_o) && run_i && $past(run_i) && $stable(cpol_i) |-> !$stable(sck_o));

   p_cs_rise_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i) |-> sck_o == cpol_i);

   p_cs_rise_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i) |=> !(shift_o || sample_o));

   p_halt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SCK_HALT) && $past(state_q == SCK_HALT) |-> !(shift_o || sample_o));
endmodule

// File: tb/tb_spi_sck_gen.sv
module tb_spi_sck_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       rd_phase = 1'b0;
   logic       stop = 1'b0;
   logic [7:0] div_wr = 8'd0;
   logic [7:0] div_rd = 8'd0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic       offline = 1'b1;
   logic       sck, sck_oe, shift_s, sample_s;

   int n_chk = 0;
   int n_fail = 0;
   bit summary_done = 1'b0;

   always #2 clk = ~clk;

   spi_sck_gen #(.DIV_W(8)) dut (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run), .rd_phase_i(rd_phase),
      .stop_i(stop), .div_wr_i(div_wr), .div_rd_i(div_rd), .cpol_i(cpol),
      .cpha_i(cpha), .offline_i(offline), .sck_o(sck), .sck_oe_o(sck_oe),
      .shift_o(shift_s), .sample_o(sample_s)
   );

   typedef struct packed {
      logic [7:0] dw;
      logic [7:0] dr;
      logic       pol;
      logic       pha;
      logic [3:0] nwr;
      logic [3:0] nrd;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'd0, 8'd0, 1'b0, 1'b0, 4'd2, 4'd1},
      '{8'd1, 8'd4, 1'b0, 1'b1, 4'd2, 4'd2},
      '{8'd3, 8'd0, 1'b1, 1'b0, 4'd1, 4'd2},
      '{8'd2, 8'd5, 1'b1, 1'b1, 4'd3, 4'd1},
      '{8'd0, 8'd7, 1'b0, 1'b0, 4'd0, 4'd2},
      '{8'd6, 8'd1, 1'b1, 1'b1, 4'd2, 4'd0}
   };

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   endtask

   // Half-period length: h=0 ends at the leading edge, h=1 at the trailing edge (R2, R3, R4).
   function automatic int half_len(vec_t v, int k, int h);
      int d, r, lng, sht;
      d   = (k < int'(v.nwr)) ? int'(v.dw) : int'(v.dr);
      r   = d + 2;
      lng = (r + 1) / 2;
      sht = r / 2;
      if (h == 0) return v.pha ? sht : lng;
      else        return v.pha ? lng : sht;
   endfunction

   task automatic do_vector(vec_t v, int vi);
      int nb, total, idx, k, h, rises, exp_idx, last_edge;
      bit exp_sample, ok;
      @(negedge clk);
      run = 1'b0; stop = 1'b0;
      div_wr = v.dw; div_rd = v.dr; cpol = v.pol; cpha = v.pha;
      nb = int'(v.nwr) + int'(v.nrd);
      rd_phase = (v.nwr == 0);
      total = 0;
      for (int b = 0; b < nb; b++)
         total += ((b < int'(v.nwr)) ? int'(v.dw) : int'(v.dr)) + 2;
      repeat (2) @(negedge clk);
      run = 1'b1;
      idx = -1; k = 0; h = 0; rises = 0; last_edge = -1;
      exp_idx = half_len(v, 0, 0);
      while (idx < total + 8) begin
         @(negedge clk);
         idx++;
         if (idx == 0) begin
            chk(sck == cpol && !shift_s && !sample_s, "R6 pin idle and quiet at run rise",
                int'(sck), int'(cpol));
         end
         if (k < nb && idx == exp_idx) begin
            exp_sample = (h == 0) ? !v.pha : v.pha;
            ok = (sample_s == exp_sample) && (shift_s == !exp_sample)
                 && (sck == ((h == 0) ? !v.pol : v.pol));
            chk(ok, $sformatf("R3/R4/R5 vec %0d bit %0d half %0d edge kind and level", vi, k, h),
                {int'(shift_s), int'(sample_s), int'(sck)},
                {int'(!exp_sample), int'(exp_sample), int'((h == 0) ? !v.pol : v.pol)});
            last_edge = idx;
            if (h == 0) begin
               rises++;
               if (rises == int'(v.nwr)) rd_phase = 1'b1;
               if (rises == nb) stop = 1'b1;
               h = 1;
               exp_idx += half_len(v, k, 1);
            end else begin
               k++;
               h = 0;
               if (k < nb) exp_idx += half_len(v, k, 0);
            end
         end else if (shift_s || sample_s) begin
            chk(1'b0, $sformatf("R7/R8 vec %0d unexpected strobe at cycle %0d", vi, idx),
                idx, exp_idx);
         end else if (k >= nb) begin
            chk(sck == v.pol, "R8 pin rests idle after stop", int'(sck), int'(v.pol));
         end
      end
      chk(last_edge == total, $sformatf("R2 vec %0d transfer length", vi), last_edge, total);
      chk(k == nb, $sformatf("R2 vec %0d bits completed", vi), k, nb);
      @(negedge clk);
      run = 1'b0; stop = 1'b0;
      repeat (2) @(negedge clk);
      chk(sck == v.pol && !shift_s && !sample_s, "R6 idle after run falls", int'(sck), int'(v.pol));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!shift_s && !sample_s, "R1 strobes low in reset", int'(shift_s | sample_s), 0);
      chk(sck == 1'b0, "R1 pin at cpol in reset", int'(sck), 0);
      chk(sck_oe == 1'b0, "R1 oe follows offline", int'(sck_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sck_oe == 1'b0, "R9 offline releases pin", int'(sck_oe), 0);
      offline = 1'b0;
      @(negedge clk);
      chk(sck_oe == 1'b1, "R9 online drives pin", int'(sck_oe), 1);
      // R6: run low with polarity 1 keeps pin high and quiet
      cpol = 1'b1;
      div_wr = 8'd0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(sck == 1'b1 && !shift_s && !sample_s, "R6 no clock while run low", int'(sck), 1);
      end
      // Vector table
      for (int vi = 0; vi < 6; vi++) do_vector(VECS[vi], vi);
      // R9 again while running
      @(negedge clk);
      offline = 1'b1;
      @(negedge clk);
      chk(sck_oe == 1'b0, "R9 offline after transfers", int'(sck_oe), 0);
      finish_run();
   end
endmodule